// File: doc/BRIEF.md
# Ping-Pong Stream Capture Controller

This block captures a continuous stream of samples into on-chip memory with no help from the processor. It holds two equal buffers. At any moment the stream side owns one of them and fills it in ascending order, while the processor owns the other and reads it through a simple synchronous read port. When the stream side has written a full block, the two buffers change owners and an interrupt tells the processor that fresh data is waiting.

The block length is set by a configuration input that holds the length minus one, so any size from 1 to the buffer depth can be set. It is sampled once after reset and again at every ownership change. Each ownership change takes one cycle, and the stream side is not ready during that cycle. An interrupt that is still pending when the next change happens raises a sticky overrun flag. An output bit reports which buffer the processor owns.

Top module: `pingpong_capture`

## Requirements
- R1: While reset is asserted, sReady, irq and overrun are 0 and cpuBuf is 1, so the processor owns buffer 1 and the first block goes into buffer 0.
- R2: The block length is cfgLenM1+1 (1 to 256 with the defaults). It is sampled in the first cycle after reset and in each swap cycle. A change of cfgLenM1 at any other time does not affect the block being filled.
- R3: A sample is accepted only in a cycle where sValid and sReady are both 1. The n-th accepted sample of a block (counting from 0) is stored at offset n of the stream-owned buffer.
- R4: sReady is 0 in the first cycle after reset and in the cycle after the last sample of a block is accepted (the swap cycle). It is 1 in every other cycle. cpuBuf toggles at the end of the swap cycle.
- R5: irq goes to 1 at the end of every swap cycle. It stays at 1 until the end of a cycle, other than a swap cycle, in which irqAck is 1.
- R6: overrun goes to 1 at the end of a swap cycle in which irq is already 1 and irqAck is 0. It then holds until the end of a cycle in which overrunClr is 1. A swap that sets overrun takes priority over a clear in the same cycle.
- R7: cpuRdData shows, one cycle after cpuAddr is presented, the word at offset cpuAddr in the buffer numbered by cpuBuf (0 or 1).
- R8: If irqAck is 1 in the swap cycle itself, overrun is not set by that swap, and irq still ends that cycle at 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| sValid | input | 1 | Stream sample valid |
| sReady | output | 1 | Block can take a sample this cycle |
| sData | input | DATA_W | Stream sample |
| cfgLenM1 | input | ADDR_W | Block length minus one |
| cpuAddr | input | ADDR_W | Processor read offset |
| cpuRdData | output | DATA_W | Registered read data from the processor-owned buffer |
| cpuBuf | output | 1 | Number of the buffer the processor owns |
| irq | output | 1 | Block-complete interrupt |
| irqAck | input | 1 | Interrupt acknowledge |
| overrun | output | 1 | Sticky flag: a swap happened while irq was still pending |
| overrunClr | input | 1 | Clears overrun |

## Verification
The assertions assume that irqAck and overrunClr are plain one-cycle or level pulses that are held stable across each clock edge. They also assume that the stream side does not depend on sReady being high during the swap cycle. The bench drives every input at the falling edge, so every value is settled before the rising edge. It reads a buffer only while the stream is idle and the block is not in its swap cycle, so that the stream never overwrites the words the processor is checking.

// File: rtl/pingpong_pkg.sv
package pingpong_pkg;

  typedef enum logic [1:0] {
    ST_LOAD = 2'd0,
    ST_FILL = 2'd1,
    ST_SWAP = 2'd2
  } ctrlState_e;

  // strobes from the control to the datapath
  typedef struct packed {
    logic wrEn;   // store sData at the current write offset
    logic swap;   // exchange buffer ownership at this edge
  } dpStrobe_t;

endpackage

// File: rtl/pp_ctrl.sv
module pp_ctrl
  import pingpong_pkg::*;
#(
  parameter int MAX_LEN = 256,
  parameter int ADDR_W  = $clog2(MAX_LEN)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sValid,
  input  logic [ADDR_W-1:0] cfgLenM1,
  input  logic              irqAck,
  input  logic              overrunClr,
  output logic              sReady,
  output dpStrobe_t         stb,
  output logic [ADDR_W-1:0] wrPtr,
  output logic              irq,
  output logic              overrun
);

  localparam logic [ADDR_W:0]   LenLimit = (ADDR_W+1)'(MAX_LEN);
  localparam logic [ADDR_W-1:0] LastMax  = ADDR_W'(MAX_LEN - 1);

  ctrlState_e        state;
  logic [ADDR_W-1:0] curLast;
  logic [ADDR_W-1:0] cfgEff;
  logic              lastBeat;

  // clamp a configured length that exceeds the buffer depth
  always_comb begin
    cfgEff = ({1'b0, cfgLenM1} >= LenLimit) ? LastMax : cfgLenM1;
  end

  always_comb begin
    sReady   = (state == ST_FILL);
    stb.wrEn = sReady && sValid;
    stb.swap = (state == ST_SWAP);
    lastBeat = stb.wrEn && (wrPtr == curLast);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_LOAD;
      wrPtr   <= '0;
      curLast <= '0;
    end else begin
      unique case (state)
        ST_LOAD: begin
          curLast <= cfgEff;
          state   <= ST_FILL;
        end
        ST_FILL: begin
          if (lastBeat) begin
            wrPtr <= '0;
            state <= ST_SWAP;
          end else if (stb.wrEn) begin
            wrPtr <= wrPtr + 1'b1;
          end
        end
        ST_SWAP: begin
          curLast <= cfgEff;
          state   <= ST_FILL;
        end
        default: state <= ST_LOAD;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      irq     <= 1'b0;
      overrun <= 1'b0;
    end else begin
      if (stb.swap)    irq <= 1'b1;
      else if (irqAck) irq <= 1'b0;

      if (stb.swap && irq && !irqAck) overrun <= 1'b1;
      else if (overrunClr)            overrun <= 1'b0;
    end
  end

endmodule

// File: rtl/pp_datapath.sv
module pp_datapath
  import pingpong_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         stb,
  input  logic [ADDR_W-1:0] wrPtr,
  input  logic [DATA_W-1:0] sData,
  input  logic [ADDR_W-1:0] cpuAddr,
  output logic [DATA_W-1:0] cpuRdData,
  output logic              cpuBuf
);

  localparam int Words = 2 * (2 ** ADDR_W);

  logic [DATA_W-1:0] bufMem [Words];
  logic              dmaBank;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) dmaBank <= 1'b0;
    else if (stb.swap) dmaBank <= ~dmaBank;
  end

  always_ff @(posedge clk) begin
    if (stb.wrEn) bufMem[{dmaBank, wrPtr}] <= sData;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) cpuRdData <= '0;
    else       cpuRdData <= bufMem[{~dmaBank, cpuAddr}];
  end

  assign cpuBuf = ~dmaBank;

endmodule

// File: rtl/pingpong_capture.sv
module pingpong_capture
  import pingpong_pkg::*;
#(
  parameter int DATA_W  = 16,
  parameter int MAX_LEN = 256,
  parameter int ADDR_W  = $clog2(MAX_LEN)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sValid,
  output logic              sReady,
  input  logic [DATA_W-1:0] sData,
  input  logic [ADDR_W-1:0] cfgLenM1,
  input  logic [ADDR_W-1:0] cpuAddr,
  output logic [DATA_W-1:0] cpuRdData,
  output logic              cpuBuf,
  output logic              irq,
  input  logic              irqAck,
  output logic              overrun,
  input  logic              overrunClr
);

  dpStrobe_t         stb;
  logic [ADDR_W-1:0] wrPtr;

  pp_ctrl #(.MAX_LEN(MAX_LEN), .ADDR_W(ADDR_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .sValid(sValid), .cfgLenM1(cfgLenM1),
    .irqAck(irqAck), .overrunClr(overrunClr), .sReady(sReady),
    .stb(stb), .wrPtr(wrPtr), .irq(irq), .overrun(overrun)
  );

  pp_datapath #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .wrPtr(wrPtr), .sData(sData),
    .cpuAddr(cpuAddr), .cpuRdData(cpuRdData), .cpuBuf(cpuBuf)
  );

endmodule

// File: rtl/pp_checker.sv
module pp_checker (
  input logic clk,
  input logic rstN,
  input logic sReady,
  input logic cpuBuf,
  input logic irq,
  input logic irqAck,
  input logic overrun,
  input logic overrunClr
);

  // R4: ownership changes only after a cycle with sReady low, and the stream is ready again right away
  a_r4_swap_gap: assert property (@(posedge clk) disable iff (!rstN)
    (cpuBuf != $past(cpuBuf)) |-> (!$past(sReady) && sReady));

  // R5: each ownership change leaves irq set
  a_r5_irq_on_swap: assert property (@(posedge clk) disable iff (!rstN)
    (cpuBuf != $past(cpuBuf)) |-> irq);

  // R5: irq rises only together with an ownership change
  a_r5_irq_cause: assert property (@(posedge clk) disable iff (!rstN)
    $rose(irq) |-> (cpuBuf != $past(cpuBuf)));

  // R5: without an acknowledge, irq holds
  a_r5_irq_hold: assert property (@(posedge clk) disable iff (!rstN)
    (irq && !irqAck) |=> irq);

  // R6: overrun is sticky until cleared
  a_r6_overrun_hold: assert property (@(posedge clk) disable iff (!rstN)
    (overrun && !overrunClr) |=> overrun);

  // R6 and R8: overrun rises only on a swap that meets a pending, unacknowledged irq
  a_r6_overrun_cause: assert property (@(posedge clk) disable iff (!rstN)
    $rose(overrun) |-> ((cpuBuf != $past(cpuBuf)) && $past(irq) && !$past(irqAck)));

endmodule

bind pingpong_capture pp_checker u_checker (
  .clk(clk), .rstN(rstN), .sReady(sReady), .cpuBuf(cpuBuf), .irq(irq),
  .irqAck(irqAck), .overrun(overrun), .overrunClr(overrunClr)
);

// File: tb/pingpong_capture_bench.sv
`timescale 1ns/1ps
module pingpong_capture_bench;

  localparam int DW = 16;
  localparam int AW = 8;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          sValid = 1'b0;
  logic          sReady;
  logic [DW-1:0] sData = '0;
  logic [AW-1:0] cfgLenM1 = 8'd3;
  logic [AW-1:0] cpuAddr = '0;
  logic [DW-1:0] cpuRdData;
  logic          cpuBuf, irq, overrun;
  logic          irqAck = 1'b0;
  logic          overrunClr = 1'b0;

  always #2.5 clk = ~clk;

  pingpong_capture u_pingpong_capture (
    .clk(clk), .rstN(rstN), .sValid(sValid), .sReady(sReady), .sData(sData),
    .cfgLenM1(cfgLenM1), .cpuAddr(cpuAddr), .cpuRdData(cpuRdData), .cpuBuf(cpuBuf),
    .irq(irq), .irqAck(irqAck), .overrun(overrun), .overrunClr(overrunClr)
  );

  int checks = 0;
  int errors = 0;

  // bench model: 0 = length load, 1 = filling, 2 = swap
  int            mSt = 0;
  int            mPtr = 0;
  int            mLen = 0;
  int            mPrevLen = 0;
  int            mSwaps = 0;
  logic          mBank = 1'b0;
  logic          mIrq = 1'b0;
  logic          mOvr = 1'b0;
  logic [DW-1:0] expMem [512];

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // one cycle: entered and left at a falling edge
  task automatic tick(input logic v, input logic [DW-1:0] d, input logic ack, input logic oclr);
    sValid = v; sData = d; irqAck = ack; overrunClr = oclr;
    chk("R2/R4 sReady", {31'd0, sReady}, {31'd0, mSt == 1});
    @(posedge clk);
    case (mSt)
      0: begin mLen = int'(cfgLenM1) + 1; mSt = 1; end
      1: begin
        if (ack) mIrq = 1'b0;
        if (oclr) mOvr = 1'b0;
        if (v) begin
          expMem[{mBank, mPtr[7:0]}] = d;   // R3
          mPtr++;
          if (mPtr == mLen) begin mPtr = 0; mSt = 2; end
        end
      end
      default: begin
        mBank = ~mBank;
        mPrevLen = mLen;
        mLen = int'(cfgLenM1) + 1;
        if (mIrq && !ack) mOvr = 1'b1;      // R6, R8
        else if (oclr) mOvr = 1'b0;
        mIrq = 1'b1;
        mSwaps++;
        mSt = 1;
      end
    endcase
    @(negedge clk);
    chk("R5 irq", {31'd0, irq}, {31'd0, mIrq});
    chk("R6 overrun", {31'd0, overrun}, {31'd0, mOvr});
    chk("R4 cpuBuf", {31'd0, cpuBuf}, {31'd0, ~mBank});
  endtask

  task automatic fillBlocks(input int n, input int pct);
    int target = mSwaps + n;
    while (mSwaps < target)
      tick(($urandom % 100) < pct, DW'($urandom), 1'b0, 1'b0);
  endtask

  // R7: read back a whole processor-owned block
  task automatic readBuf(input int n);
    for (int i = 0; i < n; i++) begin
      logic cb = ~mBank;
      cpuAddr = AW'(i);
      tick(1'b0, '0, 1'b0, 1'b0);
      chk("R3/R7 read", {16'd0, cpuRdData}, {16'd0, expMem[{cb, AW'(i)}]});
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd1357));
    for (int i = 0; i < 512; i++) expMem[i] = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1: reset values
    chk("R1 sReady", {31'd0, sReady}, 32'd0);
    chk("R1 irq", {31'd0, irq}, 32'd0);
    chk("R1 overrun", {31'd0, overrun}, 32'd0);
    chk("R1 cpuBuf", {31'd0, cpuBuf}, 32'd1);
    rstN = 1'b1;

    // R2, R3, R7: length 4, gappy stream, three blocks with reads
    for (int b = 0; b < 3; b++) begin
      fillBlocks(1, 70);
      readBuf(4);
      tick(1'b0, '0, 1'b1, 1'b0);
    end

    // R2: length 1, every accepted sample swaps; no acks give overruns (R6)
    cfgLenM1 = 8'd0;
    fillBlocks(4, 100);
    readBuf(1);
    tick(1'b0, '0, 1'b1, 1'b1);

    // R2: change of length in mid-block is deferred to the next swap
    cfgLenM1 = 8'd5;
    fillBlocks(2, 100);
    tick(1'b0, '0, 1'b1, 1'b0);
    for (int i = 0; i < 3; i++) tick(1'b1, DW'($urandom), 1'b0, 1'b0);
    cfgLenM1 = 8'd1;
    fillBlocks(1, 100);
    readBuf(6);
    tick(1'b0, '0, 1'b1, 1'b0);

    // R6: two unacknowledged swaps, sticky flag, then clear
    fillBlocks(2, 100);
    repeat (5) tick(1'b0, '0, 1'b0, 1'b0);
    tick(1'b0, '0, 1'b0, 1'b1);

    // R8: acknowledge lands exactly in the swap cycle
    while (mSt != 2) tick(1'b1, DW'($urandom), 1'b0, 1'b0);
    tick(1'b0, '0, 1'b1, 1'b0);
    tick(1'b0, '0, 1'b1, 1'b0);

    // R2: maximum length 256
    cfgLenM1 = 8'd255;
    fillBlocks(2, 100);
    readBuf(256);
    tick(1'b0, '0, 1'b1, 1'b1);

    // random mix
    cfgLenM1 = 8'd7;
    for (int k = 0; k < 3000; k++) begin
      if (($urandom % 100) == 0) cfgLenM1 = AW'($urandom % 16);
      if (mIrq && mSt == 1 && ($urandom % 100) < 20) readBuf(mPrevLen);
      tick(($urandom % 100) < 75, DW'($urandom),
           ($urandom % 100) < 5, ($urandom % 100) < 3);
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule